// File: doc/BRIEF.md
# Multiplier-free constant dot product

This block computes z = sum of A_i * x_i for N_IN signed input words x_i and a coefficient vector A fixed by parameter. It has no multipliers. A combinational table holds every subset sum of the coefficients. Each cycle the table is addressed by the bits of one common weight, taken from all inputs at once. A shift-and-add accumulator folds the table outputs into the result.

The bit slices are handled from the sign bit down to the least significant bit. The parameter C_BITS sets how many slices one cycle handles: C_BITS table copies are read side by side, and their outputs are summed with the shifted accumulator. One dot product therefore takes W_IN / C_BITS cycles.

The user presents the operand words and pulses `load_i` while `ready_o` is high. After the computation, `done_o` is high for exactly one cycle and `z_o` holds the full-precision result.

Top module: `da_dot`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ready_o` is 1, `done_o` is 0 and `z_o` is 0.
- R2: With every input word equal to 0 or 1, `z_o` equals the sum of the coefficients A_i whose word x_i is 1. This is the table entry whose address bit i is x_i.
- R3: `z_o` equals sum of A_i * x_i. Each x_i is the 16-bit two's-complement field at bits [16*i+15 : 16*i] of `x_i`. The sign slice is subtracted and the rest are added. The result is exact in 32 bits, including x_i = -32768.
- R4: `done_o` rises exactly W_IN / C_BITS clock edges after the edge that accepts a load, and stays high for one cycle only.
- R5: While a computation is in progress, `ready_o` is 0 and `load_i` has no effect. The result and the done timing of the running computation are unchanged.
- R6: `ready_o` is 1 in the cycle in which `done_o` is 1. A load presented in that cycle is accepted.
- R7: `z_o` keeps its value in every cycle in which `done_o` is 0.
- R8: A build with C_BITS = 1 produces the same result as the default build with C_BITS = 2, after W_IN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Start request; sampled only while ready |
| x_i | input | N_IN*W_IN | Operand words; word i at bits [W_IN*i +: W_IN] |
| ready_o | output | 1 | Idle; a load will be accepted |
| done_o | output | 1 | One-cycle pulse; z_o valid |
| z_o | output | ACC_W | Signed dot product |

## Verification
The finishing step and the acceptance of a new load can fall in the same cycle. A load is driven in exactly the cycle where `done_o` is high. The bench then checks that the finished result is intact, that the new operands were taken, and that their result arrives W_IN / C_BITS cycles later. A second collision pairs a load with a busy cycle; it is judged by an unchanged result and unchanged done timing. A sweep over corner values runs the 2-bit and 1-bit builds side by side and compares each of them to an arithmetic reference.

// File: rtl/da_pkg.sv
package da_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} da_state_e;
endpackage

// File: rtl/da_lut.sv
module da_lut #(
  parameter int N_IN   = 4,
  parameter int COEF_W = 12,
  parameter int SUM_W  = 15,
  parameter logic [N_IN*COEF_W-1:0] COEFS = '0
) (
  input  logic [N_IN-1:0]  addr_i,
  output logic [SUM_W-1:0] sum_o
);
  localparam int DEPTH = 1 << N_IN;

  function automatic logic [SUM_W-1:0] subset_sum(input int k);
    logic [SUM_W-1:0] s;
    logic [COEF_W-1:0] c;
    s = '0;
    for (int i = 0; i < N_IN; i++) begin
      c = COEFS[i*COEF_W +: COEF_W];
      if (((k >> i) & 1) == 1)
        s = s + {{(SUM_W-COEF_W){c[COEF_W-1]}}, c};
    end
    return s;
  endfunction

  logic [SUM_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    assign tbl[k] = subset_sum(k);
  end

  assign sum_o = tbl[addr_i];
endmodule

// File: rtl/da_acc.sv
module da_acc #(
  parameter int C_BITS = 2,
  parameter int SUM_W  = 15,
  parameter int ACC_W  = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          step_i,
  input  logic                          first_i,
  input  logic [C_BITS-1:0][SUM_W-1:0]  lut_i,
  output logic signed [ACC_W-1:0]       acc_nx_o
);
  logic signed [ACC_W-1:0] acc_q;

  // (C_BITS+1)-input adder; slice k carries weight 2^(C_BITS-1-k)
  always_comb begin
    logic signed [ACC_W-1:0] term;
    acc_nx_o = acc_q <<< C_BITS;
    for (int k = 0; k < C_BITS; k++) begin
      term = {{(ACC_W-SUM_W){lut_i[k][SUM_W-1]}}, lut_i[k]};
      term = term <<< (C_BITS-1-k);
      if (first_i && k == 0) acc_nx_o = acc_nx_o - term;  // sign slice
      else                   acc_nx_o = acc_nx_o + term;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (step_i) acc_q <= acc_nx_o;
  end

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));
endmodule

// File: rtl/da_ctrl.sv
module da_ctrl
  import da_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ready_o,
  output logic accept_o,
  output logic step_o,
  output logic first_o,
  output logic last_o,
  output logic done_o
);
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEPS-1);

  da_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && load_i;
  assign step_o   = (state_q == ST_RUN);
  assign first_o  = step_o && (cnt_q == '0);
  assign last_o   = step_o && (cnt_q == CNT_LAST);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (last_o) begin
        state_q <= ST_IDLE;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && STEPS > 1) |=> !done_o);
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (cnt_q <= CNT_LAST));
  p_busy_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !last_o) |=> (step_o && !ready_o));
  p_ready_at_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
endmodule

// File: rtl/da_dot.sv
module da_dot #(
  parameter int N_IN   = 4,
  parameter int W_IN   = 16,
  parameter int C_BITS = 2,
  parameter int COEF_W = 12,
  parameter int ACC_W  = 32,
  parameter logic [N_IN*COEF_W-1:0] COEFS = {12'h7FF, 12'h800, 12'h12C, 12'hFF9}
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [N_IN*W_IN-1:0]   x_i,
  output logic                   ready_o,
  output logic                   done_o,
  output logic signed [ACC_W-1:0] z_o
);
  localparam int STEPS = W_IN / C_BITS;
  localparam int SUM_W = COEF_W + $clog2(N_IN) + 1;

  logic [N_IN-1:0][W_IN-1:0]    x_q;
  logic [C_BITS-1:0][N_IN-1:0]  addr;
  logic [C_BITS-1:0][SUM_W-1:0] lut_out;
  logic signed [ACC_W-1:0]      acc_nx;
  logic signed [ACC_W-1:0]      z_q;
  logic accept, step, first, last;

  da_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i, .rst_ni, .load_i,
    .ready_o, .accept_o(accept), .step_o(step),
    .first_o(first), .last_o(last), .done_o
  );

  // one table copy per slice handled in a cycle
  for (genvar k = 0; k < C_BITS; k++) begin : g_slice
    for (genvar i = 0; i < N_IN; i++) begin : g_bit
      assign addr[k][i] = x_q[i][W_IN-1-k];
    end
    da_lut #(.N_IN(N_IN), .COEF_W(COEF_W), .SUM_W(SUM_W), .COEFS(COEFS)) u_lut (
      .addr_i(addr[k]),
      .sum_o (lut_out[k])
    );
  end

  da_acc #(.C_BITS(C_BITS), .SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni,
    .clr_i(accept), .step_i(step), .first_i(first),
    .lut_i(lut_out), .acc_nx_o(acc_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      z_q <= '0;
    end else begin
      if (accept) x_q <= x_i;
      else if (step) begin
        for (int i = 0; i < N_IN; i++) x_q[i] <= x_q[i] << C_BITS;
      end
      if (last) z_q <= acc_nx;
    end
  end

  assign z_o = z_q;

  p_z_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(z_o));
  p_no_accept_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && load_i) |=> $stable(z_o) || done_o);
endmodule

// File: tb/tb_da_dot.sv
module tb_da_dot;
  localparam int STEPS_P = 8;
  localparam int STEPS_S = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        load_p = 1'b0, load_s = 1'b0;
  logic [63:0] xp = '0, xs = '0;
  logic        ready_p, done_p, ready_s, done_s;
  logic signed [31:0] z_p, z_s;

  da_dot #(.C_BITS(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_p), .x_i(xp),
    .ready_o(ready_p), .done_o(done_p), .z_o(z_p)
  );
  da_dot #(.C_BITS(1)) dut_s (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_s), .x_i(xs),
    .ready_o(ready_s), .done_o(done_s), .z_o(z_s)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 190000);
    errors++;
    $display("FAIL watchdog: got cycle %0d expected below 190000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] model(input logic [63:0] v);
    int coef [4] = '{-7, 300, -2048, 2047};
    longint s = 0;
    for (int i = 0; i < 4; i++) s += longint'($signed(v[16*i +: 16])) * coef[i];
    return s[31:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic bit is_bin(input logic [63:0] v);
    bit r = 1'b1;
    for (int i = 0; i < 4; i++)
      if (v[16*i +: 16] > 16'd1) r = 1'b0;
    return r;
  endfunction

  // both builds on the same operands
  task automatic run_pair(input logic [63:0] v);
    bit dp_ok = 1'b1, ds_ok = 1'b1;
    logic [31:0] zp_c = '0, zs_c = '0;
    string tag;
    tag = is_bin(v) ? "R2" : "R3";
    load_p = 1'b1; load_s = 1'b1; xp = v; xs = v;
    @(negedge clk);
    load_p = 1'b0; load_s = 1'b0;
    for (int k = 1; k <= STEPS_S; k++) begin
      @(negedge clk);
      if (k <= STEPS_P && done_p != (k == STEPS_P)) dp_ok = 1'b0;
      if (k == STEPS_P) zp_c = z_p;
      if (done_s != (k == STEPS_S)) ds_ok = 1'b0;
      if (k == STEPS_S) zs_c = z_s;
    end
    chk(dp_ok, "R4 done timing c=2", dp_ok, 1);
    chk(ds_ok, "R4 done timing c=1", ds_ok, 1);
    chk(zp_c == model(v), tag, $signed(zp_c), $signed(model(v)));
    chk(zs_c == model(v), "R8 c=1 result", $signed(zs_c), $signed(model(v)));
  endtask

  logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h5A3C};

  initial begin
    logic [63:0] va, vb, vc;
    bit rdy_ok, dn_ok;
    logic [31:0] zc;
    repeat (3) @(negedge clk);
    chk(ready_p == 1 && done_p == 0 && z_p == 0, "R1 in reset", {ready_p, done_p}, 2);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ready_p == 1 && done_p == 0 && z_p == 0, "R1 after reset", z_p, 0);

    // R5: load during busy is ignored
    va = {16'h8000, 16'h7FFF, 16'hFFFF, 16'h1234};
    vb = {16'h0001, 16'h0002, 16'h0003, 16'h0004};
    vc = {16'hF00D, 16'h0BAD, 16'h8001, 16'h7FFE};
    load_p = 1'b1; xp = va;
    @(negedge clk);
    load_p = 1'b0;
    rdy_ok = 1'b1; dn_ok = 1'b1;
    for (int k = 1; k <= STEPS_P; k++) begin
      @(negedge clk);
      load_p = 1'b0;
      if (k < STEPS_P && ready_p) rdy_ok = 1'b0;
      if (done_p != (k == STEPS_P)) dn_ok = 1'b0;
      if (k == 3) begin load_p = 1'b1; xp = vb; end
    end
    chk(rdy_ok, "R5 ready low while busy", rdy_ok, 1);
    chk(dn_ok, "R5 done timing with busy load", dn_ok, 1);
    chk(z_p == model(va), "R5 busy load ignored", z_p, $signed(model(va)));
    chk(ready_p == 1'b1, "R6 ready during done", ready_p, 1);

    // R6: load in the done cycle
    load_p = 1'b1; xp = vc;
    @(negedge clk);
    load_p = 1'b0;
    chk(done_p == 1'b0 && ready_p == 1'b0, "R6 load taken at done", {done_p, ready_p}, 0);
    dn_ok = 1'b1;
    for (int k = 1; k <= STEPS_P; k++) begin
      @(negedge clk);
      if (done_p != (k == STEPS_P)) dn_ok = 1'b0;
    end
    chk(dn_ok, "R6 second done timing", dn_ok, 1);
    chk(z_p == model(vc), "R6 second result", z_p, $signed(model(vc)));

    // R7: result holds
    zc = z_p;
    repeat (5) @(negedge clk);
    chk(z_p == zc && done_p == 1'b0, "R7 z held", z_p, $signed(zc));

    // sweep over corner values on both builds
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 6; c++)
          for (int d = 0; d < 6; d++)
            run_pair({vals[d], vals[c], vals[b], vals[a]});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule